// File: doc/BRIEF.md
# Slot Hotplug Event and Eject Controller

This block tracks device insertion and removal on a bus of up to `NSLOT` slots and reports them to system software. It holds a 16-bit event status register and a 16-bit event enable register, each reached one byte at a time. It also holds two slot-wide masks that record which slot was most recently inserted or removed. When an insert or remove notice arrives with a slot number, the block clears both masks and marks only that slot. It then sets the hotplug bit (bit 1) of event status and, if the matching enable bit is set, raises a one-cycle interrupt pulse.

A separate eject port lets software request that a slot be torn down. Software writes a one-hot slot mask, and the block turns it into a one-cycle eject strobe together with the index of the lowest set bit. The actual teardown of the device and bus enumeration happen elsewhere.

The interrupt pulse comes from a three-state machine. In `IRQ_IDLE` the output is low. The transition *arm* goes from `IRQ_IDLE` to `IRQ_FIRE` when an enabled event arrives. `IRQ_FIRE` drives the output high for one cycle and then takes one of two transitions: *settle* returns to `IRQ_IDLE` when no new enabled event arrives, and *defer* moves to `IRQ_HOLD` when one does. `IRQ_HOLD` drives the output low for one cycle and then takes *refire* back to `IRQ_FIRE`; further events seen in `IRQ_HOLD` are merged into that pulse.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: After reset, event status, event enable and both slot masks read as zero, `irq` is low and `ej_strobe` is low.
- R2: The event byte port maps address 0 to status bits 7:0, address 1 to status bits 15:8, address 2 to enable bits 7:0 and address 3 to enable bits 15:8. Reads on `ev_rdata` are combinational.
- R3: A byte write to status address 0 or 1 clears every bit written as 1 in the addressed byte. It leaves all other status bits unchanged.
- R4: A byte write to enable address 2 or 3 replaces the addressed byte with the written data. It leaves the other enable byte unchanged.
- R5: On the mask word port, offset 0 is the inserted mask and offset 4 is the removed mask; both read back what was last written. Any other offset reads 0, and a write to any other offset changes neither mask.
- R6: A hotplug notice (`hp_valid`) clears both masks. It then sets bit `hp_slot` of the inserted mask when `hp_insert` is 1, or of the removed mask when `hp_insert` is 0, and it sets status bit 1. All of this is visible the cycle after the notice.
- R7: A notice that arrives while enable bit 1 is set drives `irq` high for exactly one cycle, the cycle after the notice. With enable bit 1 clear, `irq` stays low.
- R8: An enabled notice that arrives in the cycle `irq` is high is answered by a second pulse after exactly one low cycle. Enabled notices that arrive during that low cycle are merged into the second pulse.
- R9: A write of nonzero data to the eject port drives `ej_strobe` high for one cycle, the cycle after the write, with `ej_slot` equal to the index of the lowest set bit of the data. A write of zero produces no strobe.
- R10: `ej_rdata` always reads 0.
- R11: When a notice and a status-clearing write to address 0 with bit 1 set happen in the same cycle, status bit 1 ends set. When a notice and a mask word write happen in the same cycle, the masks take the notice's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_we | input | 1 | Event byte port write enable |
| ev_addr | input | 2 | Event byte address (0..3) |
| ev_wdata | input | 8 | Event byte write data |
| ev_rdata | output | 8 | Event byte read data |
| mask_we | input | 1 | Slot mask word write enable |
| mask_addr | input | 3 | Slot mask word offset (0 inserted, 4 removed) |
| mask_wdata | input | NSLOT | Slot mask write data |
| mask_rdata | output | NSLOT | Slot mask read data |
| ej_we | input | 1 | Eject port write enable |
| ej_wdata | input | NSLOT | Eject port write data |
| ej_rdata | output | NSLOT | Eject port read data, always zero |
| ej_strobe | output | 1 | One-cycle eject request |
| ej_slot | output | $clog2(NSLOT) | Slot index of the eject request |
| hp_valid | input | 1 | Hotplug notice valid |
| hp_insert | input | 1 | 1 = insertion, 0 = removal |
| hp_slot | input | $clog2(NSLOT) | Slot number of the notice |
| irq | output | 1 | Hotplug interrupt pulse |

## Verification
The bench builds the block with its default `NSLOT` of 32. At that width the masks and the eject data fill a whole 32-bit word, so notices for slot 31 and eject writes with only the top bit set exercise the highest mask bit and the longest priority chain of the eject decoder. A five-bit `hp_slot` then reaches every slot without any out-of-range value. Directed sequences of back-to-back and triple notices walk the interrupt machine through every state and transition. Same-cycle notice-and-write cases pin down the priority rules.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int EV_W   = 16;
    localparam int HP_BIT = 1;
    localparam logic [EV_W-1:0] HP_MASK = EV_W'(1) << HP_BIT;

    localparam logic [2:0] OFS_INSERTED = 3'd0;
    localparam logic [2:0] OFS_REMOVED  = 3'd4;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_FIRE = 2'd1,
        IRQ_HOLD = 2'd2
    } irq_state_t;

endpackage

// File: rtl/hp_event_regs.sv
module hp_event_regs
    import hp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [7:0]      wdata,
    input  logic            hp_set,
    output logic [7:0]      rdata,
    output logic [EV_W-1:0] sts_q,
    output logic [EV_W-1:0] en_q
);

    localparam int LANES = EV_W / 8;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic       hit_sts;
        logic       hit_en;
        logic [7:0] clr_bits;
        logic [7:0] set_bits;
        logic [7:0] sts_lane;
        logic [7:0] en_lane;

        assign hit_sts  = we && (addr == 2'(b));
        assign hit_en   = we && (addr == 2'(LANES + b));
        assign clr_bits = hit_sts ? wdata : 8'h00;
        assign set_bits = hp_set ? HP_MASK[8*b +: 8] : 8'h00;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts_lane <= 8'h00;
                en_lane  <= 8'h00;
            end else begin
                sts_lane <= (sts_lane & ~clr_bits) | set_bits;
                if (hit_en) begin
                    en_lane <= wdata;
                end
            end
        end

        assign sts_q[8*b +: 8] = sts_lane;
        assign en_q[8*b +: 8]  = en_lane;
    end

    always_comb begin
        unique case (addr)
            2'd0:    rdata = sts_q[7:0];
            2'd1:    rdata = sts_q[15:8];
            2'd2:    rdata = en_q[7:0];
            default: rdata = en_q[15:8];
        endcase
    end

endmodule

// File: rtl/hp_slot_masks.sv
module hp_slot_masks
    import hp_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [NSLOT-1:0] wdata,
    input  logic             ev_valid,
    input  logic             ev_insert,
    input  logic [SW-1:0]    ev_slot,
    output logic [NSLOT-1:0] rdata,
    output logic [NSLOT-1:0] ins_q,
    output logic [NSLOT-1:0] rem_q
);

    logic [NSLOT-1:0] slot_oh;

    assign slot_oh = (32'(ev_slot) < NSLOT) ? (NSLOT'(1) << ev_slot) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ins_q <= '0;
            rem_q <= '0;
        end else if (ev_valid) begin
            ins_q <= ev_insert ? slot_oh : '0;
            rem_q <= ev_insert ? '0 : slot_oh;
        end else if (we) begin
            if (addr == OFS_INSERTED) begin
                ins_q <= wdata;
            end
            if (addr == OFS_REMOVED) begin
                rem_q <= wdata;
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_INSERTED: rdata = ins_q;
            OFS_REMOVED:  rdata = rem_q;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/hp_irq_fsm.sv
module hp_irq_fsm
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    output logic irq
);

    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (fire_req) state_d = IRQ_FIRE;
            IRQ_FIRE: state_d = fire_req ? IRQ_HOLD : IRQ_IDLE;
            IRQ_HOLD: state_d = IRQ_FIRE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_FIRE: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/hp_eject.sv
module hp_eject #(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NSLOT-1:0] wdata,
    output logic [NSLOT-1:0] rdata,
    output logic             strobe,
    output logic [SW-1:0]    slot
);

    function automatic logic [SW-1:0] first_set(input logic [NSLOT-1:0] v);
        logic [SW-1:0] idx;
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (v[i]) begin
                idx = SW'(i);
            end
        end
        return idx;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            slot   <= '0;
        end else begin
            strobe <= we && (wdata != '0);
            if (we && (wdata != '0)) begin
                slot <= first_set(wdata);
            end
        end
    end

    assign rdata = '0;

endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
    import hp_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_we,
    input  logic [1:0]       ev_addr,
    input  logic [7:0]       ev_wdata,
    output logic [7:0]       ev_rdata,
    input  logic             mask_we,
    input  logic [2:0]       mask_addr,
    input  logic [NSLOT-1:0] mask_wdata,
    output logic [NSLOT-1:0] mask_rdata,
    input  logic             ej_we,
    input  logic [NSLOT-1:0] ej_wdata,
    output logic [NSLOT-1:0] ej_rdata,
    output logic             ej_strobe,
    output logic [SW-1:0]    ej_slot,
    input  logic             hp_valid,
    input  logic             hp_insert,
    input  logic [SW-1:0]    hp_slot,
    output logic             irq
);

    logic [EV_W-1:0]  w_sts;
    logic [EV_W-1:0]  w_en;
    logic [NSLOT-1:0] w_ins;
    logic [NSLOT-1:0] w_rem;
    logic             w_fire_req;

    assign w_fire_req = hp_valid && w_en[HP_BIT];

    hp_event_regs i_ev (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ev_we),
        .addr   (ev_addr),
        .wdata  (ev_wdata),
        .hp_set (hp_valid),
        .rdata  (ev_rdata),
        .sts_q  (w_sts),
        .en_q   (w_en)
    );

    hp_slot_masks #(.NSLOT(NSLOT)) i_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mask_we),
        .addr      (mask_addr),
        .wdata     (mask_wdata),
        .ev_valid  (hp_valid),
        .ev_insert (hp_insert),
        .ev_slot   (hp_slot),
        .rdata     (mask_rdata),
        .ins_q     (w_ins),
        .rem_q     (w_rem)
    );

    hp_irq_fsm i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_req (w_fire_req),
        .irq      (irq)
    );

    hp_eject #(.NSLOT(NSLOT)) i_ej (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ej_we),
        .wdata  (ej_wdata),
        .rdata  (ej_rdata),
        .strobe (ej_strobe),
        .slot   (ej_slot)
    );

endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hp_valid,
    input logic [SW-1:0]    hp_slot,
    input logic             ej_we,
    input logic [NSLOT-1:0] ej_wdata,
    input logic [NSLOT-1:0] ej_rdata,
    input logic             ej_strobe,
    input logic [SW-1:0]    ej_slot,
    input logic             irq,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic [NSLOT-1:0] ins,
    input logic [NSLOT-1:0] rem
);

    logic [NSLOT-1:0] last_ej;
    logic [NSLOT-1:0] below_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_ej <= '0;
        end else if (ej_we) begin
            last_ej <= ej_wdata;
        end
    end

    assign below_slot = ~({NSLOT{1'b1}} << ej_slot);

    // R6
    a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> sts[1]);

    // R6
    a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && (32'(hp_slot) < NSLOT)) |=> ($countones(ins | rem) == 1));

    // R7
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    a_r7_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && en[1] && !irq) |=> irq);

    // R8
    a_r8_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && en[1] && irq) |=> !irq ##1 irq);

    // R9
    a_r9_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_we && (ej_wdata == '0)) |=> !ej_strobe);

    // R9
    a_r9_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        ej_strobe |-> (last_ej[ej_slot] && ((last_ej & below_slot) == '0)));

    // R10
    a_r10_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ej_rdata == '0);

endmodule

bind slot_hotplug_ctrl hp_checker #(.NSLOT(NSLOT)) i_hp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hp_valid  (hp_valid),
    .hp_slot   (hp_slot),
    .ej_we     (ej_we),
    .ej_wdata  (ej_wdata),
    .ej_rdata  (ej_rdata),
    .ej_strobe (ej_strobe),
    .ej_slot   (ej_slot),
    .irq       (irq),
    .sts       (w_sts),
    .en        (w_en),
    .ins       (w_ins),
    .rem       (w_rem)
);

// File: tb/test_slot_hotplug_ctrl.sv
`timescale 1ns/100ps
module test_slot_hotplug_ctrl;

    localparam int NSLOT = 32;
    localparam int SW    = $clog2(NSLOT);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_we = 1'b0;
    logic [1:0]       ev_addr = '0;
    logic [7:0]       ev_wdata = '0;
    logic [7:0]       ev_rdata;
    logic             mask_we = 1'b0;
    logic [2:0]       mask_addr = '0;
    logic [NSLOT-1:0] mask_wdata = '0;
    logic [NSLOT-1:0] mask_rdata;
    logic             ej_we = 1'b0;
    logic [NSLOT-1:0] ej_wdata = '0;
    logic [NSLOT-1:0] ej_rdata;
    logic             ej_strobe;
    logic [SW-1:0]    ej_slot;
    logic             hp_valid = 1'b0;
    logic             hp_insert = 1'b0;
    logic [SW-1:0]    hp_slot = '0;
    logic             irq;

    always #2.5 clk = ~clk;

    slot_hotplug_ctrl #(.NSLOT(NSLOT)) i_slot_hotplug_ctrl (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0]      m_sts = '0;
    logic [15:0]      m_en  = '0;
    logic [NSLOT-1:0] m_ins = '0;
    logic [NSLOT-1:0] m_rem = '0;
    logic             exp_irq = 1'b0;
    logic             exp_strobe = 1'b0;
    logic [SW-1:0]    exp_slot = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ev_byte(input int a);
        case (a)
            0:       return m_sts[7:0];
            1:       return m_sts[15:8];
            2:       return m_en[7:0];
            default: return m_en[15:8];
        endcase
    endfunction

    function automatic logic [NSLOT-1:0] mask_word(input int a);
        if (a == 0) return m_ins;
        if (a == 4) return m_rem;
        return '0;
    endfunction

    function automatic logic [SW-1:0] lowest(input logic [NSLOT-1:0] v);
        for (int i = 0; i < NSLOT; i++) begin
            if (v[i]) return SW'(i);
        end
        return '0;
    endfunction

    task automatic check_regs();
        for (int a = 0; a < 4; a++) begin
            ev_addr = 2'(a);
            #0.1;
            chk("R2 event byte read", 64'(ev_rdata), 64'(ev_byte(a)));
        end
        for (int a = 0; a < 8; a++) begin
            mask_addr = 3'(a);
            #0.1;
            chk("R5 mask word read", 64'(mask_rdata), 64'(mask_word(a)));
        end
        chk("R10 eject read", 64'(ej_rdata), 64'd0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ev_we = 1'b0; mask_we = 1'b0; ej_we = 1'b0; hp_valid = 1'b0;
        chk("R7 irq", 64'(irq), 64'(exp_irq));
        chk("R9 eject strobe", 64'(ej_strobe), 64'(exp_strobe));
        if (exp_strobe) chk("R9 eject slot", 64'(ej_slot), 64'(exp_slot));
        exp_irq = 1'b0;
        exp_strobe = 1'b0;
        check_regs();
    endtask

    task automatic model_ev_write(input int a, input logic [7:0] d);
        if (a < 2) m_sts[8*a +: 8] = m_sts[8*a +: 8] & ~d;
        else       m_en[8*(a-2) +: 8] = d;
    endtask

    task automatic model_event(input logic ins, input int s);
        m_ins = '0;
        m_rem = '0;
        if (ins) m_ins[s] = 1'b1;
        else     m_rem[s] = 1'b1;
        m_sts[1] = 1'b1;
    endtask

    task automatic ev_write(input int a, input logic [7:0] d);
        ev_we = 1'b1; ev_addr = 2'(a); ev_wdata = d;
        model_ev_write(a, d);
        tick();
    endtask

    task automatic mask_write(input int a, input logic [NSLOT-1:0] d);
        mask_we = 1'b1; mask_addr = 3'(a); mask_wdata = d;
        if (a == 0) m_ins = d;
        if (a == 4) m_rem = d;
        tick();
    endtask

    task automatic hotplug(input logic ins, input int s);
        hp_valid = 1'b1; hp_insert = ins; hp_slot = SW'(s);
        exp_irq = m_en[1];
        model_event(ins, s);
        tick();
        tick();
    endtask

    task automatic eject(input logic [NSLOT-1:0] d);
        ej_we = 1'b1; ej_wdata = d;
        exp_strobe = (d != '0);
        exp_slot = lowest(d);
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd7919);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 irq after reset", 64'(irq), 64'd0);
        chk("R1 strobe after reset", 64'(ej_strobe), 64'd0);
        check_regs();
        rst_n = 1'b1;
        tick();

        // R6 with enable clear: no pulse (R7)
        hotplug(1'b1, 5);
        hotplug(1'b0, 31);
        // R3: clearing high byte leaves bit 1 set
        ev_write(1, 8'hFF);
        ev_write(0, 8'hFD);
        ev_write(0, 8'h02);
        // R4: enable bytes independent
        ev_write(3, 8'hA5);
        ev_write(2, 8'h02);
        ev_write(3, 8'h00);
        // R7: enabled pulse
        hotplug(1'b1, 0);
        // R5: masks and unused offsets
        mask_write(0, 32'hDEAD_BEEF);
        mask_write(4, 32'h1234_5678);
        mask_write(2, 32'hFFFF_FFFF);
        mask_write(7, 32'hFFFF_FFFF);

        // R11: event wins over same-cycle status clear and mask write
        ev_we = 1'b1; ev_addr = 2'd0; ev_wdata = 8'hFF;
        mask_we = 1'b1; mask_addr = 3'd0; mask_wdata = 32'hFFFF_FFFF;
        hp_valid = 1'b1; hp_insert = 1'b0; hp_slot = 5'd9;
        model_ev_write(0, 8'hFF);
        model_event(1'b0, 9);
        exp_irq = 1'b1;
        tick();
        chk("R11 status bit1 kept", 64'(m_sts[1]), 64'd1);
        tick();

        // R8: back-to-back and triple notices
        hp_valid = 1'b1; hp_insert = 1'b1; hp_slot = 5'd3;
        model_event(1'b1, 3); exp_irq = 1'b1; tick();
        hp_valid = 1'b1; hp_insert = 1'b1; hp_slot = 5'd4;
        model_event(1'b1, 4); exp_irq = 1'b0; tick();
        hp_valid = 1'b1; hp_insert = 1'b0; hp_slot = 5'd6;
        model_event(1'b0, 6); exp_irq = 1'b1; tick();
        exp_irq = 1'b0; tick();
        tick();

        // R9: eject corner cases
        eject('0);
        eject(32'h8000_0000);
        eject(32'hFFFF_FFFF);
        eject(32'h0001_0100);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 5)
                0: ev_write(int'($urandom % 4), 8'($urandom));
                1: mask_write(int'($urandom % 8), NSLOT'($urandom));
                2: hotplug(1'($urandom), int'($urandom % NSLOT));
                3: eject(NSLOT'($urandom & $urandom & $urandom));
                default: tick();
            endcase
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule